// File: doc/BRIEF.md
# Register Window Spill/Fill Engine

This block moves one register window between a windowed register file and memory in hardware, so that a window overflow or underflow needs no trap handler. On a spill it reads the locals and ins of the target window and writes them as eight doublewords into that window's 64-byte save area. On a fill it reads the same area back and writes the pairs into the register file. The save area always starts at the target window's own stack pointer.

A start pulse names the operation kind and the current window pointer. While the engine runs, the invalid-window mask it owns reads as zero, so no window trap can fire. When the last doubleword completes, the mask takes the old value rotated by one place. The register file is reached through a window-relative pair port. Memory is reached through a valid/ready request channel with a separate acknowledge. A request stays asserted, with address, direction and data unchanged, until the cycle in which ready is high. The engine then issues nothing until the acknowledge arrives, so at most one doubleword is ever in flight. The acknowledge needs no ready of its own, because the engine accepts it in any cycle it waits for one.

Top module: `rwin_spill_fill`

## Requirements
- R1: After reset, busy, done, error, request valid and register write are all low, and the mask equals the INIT_WIM parameter (default 8'h01).
- R2: A start pulse while idle is accepted, and busy is high from the next cycle. kind_i is 0 for a spill and 1 for a fill. A start pulse while busy has no effect on the running operation.
- R3: The target window is cwp−1 for a spill and cwp+2 for a fill, both modulo NWIN. In the cycle after acceptance, the engine reads window register 14 (the stack pointer) of that window. Its value is bits 63:32 of the pair read.
- R4: Transfer k (0..7) uses window registers 16+2k and 17+2k at address base+8k. The even register sits in bits 63:32. The sequence runs in order, lowest k first.
- R5: A spill issues write requests (write flag 1) whose data is the pair read at that moment, so memory ends up holding the window's locals and ins.
- R6: A fill issues read requests (write flag 0). In the cycle the acknowledge arrives, the engine asserts the register write with the acknowledge data, for the pair of that transfer in the target window.
- R7: A request is held, with its address stable, until ready is high. After the handshake, no new request appears until the acknowledge arrives.
- R8: While busy is high the mask reads all zeros.
- R9: At the end of a spill, the mask becomes the old mask rotated right by one place (bit 0 moves to bit NWIN−1).
- R10: At the end of a fill, the mask becomes the old mask rotated left by one place (bit NWIN−1 moves to bit 0).
- R11: done is high for exactly one cycle. That cycle is the first one in which busy is low and the new mask is visible.
- R12: If the stack pointer has any of bits 2:0 set, no memory request is issued. Busy drops after one cycle and the mask returns to its value before the start. done stays low, and the error flag stays high until the next accepted start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Start pulse |
| kind_i | input | 1 | 0 spill, 1 fill |
| cwp_i | input | WP_W | Current window pointer |
| busy_o | output | 1 | Operation in progress |
| done_o | output | 1 | One-cycle completion pulse |
| err_o | output | 1 | Misaligned stack pointer seen |
| wim_o | output | NWIN | Invalid-window mask |
| rf_win_o | output | WP_W | Window addressed in the register file |
| rf_reg_o | output | 5 | Even register index within the window |
| rf_rdata_i | input | 64 | Pair read {reg, reg+1} |
| rf_we_o | output | 1 | Pair write enable |
| rf_wdata_o | output | 64 | Pair write data {reg, reg+1} |
| mem_req_valid_o | output | 1 | Memory request valid |
| mem_req_ready_i | input | 1 | Memory request ready |
| mem_req_write_o | output | 1 | 1 write, 0 read |
| mem_req_addr_o | output | AW | Byte address, 8-byte aligned |
| mem_req_wdata_o | output | 64 | Write data |
| mem_rsp_valid_i | input | 1 | Acknowledge, with read data on a read |
| mem_rsp_rdata_i | input | 64 | Read data |

## Verification
A wrong window index shows on rf_win_o in the cycle after the start is accepted, before any memory traffic. A slipped pair counter shows in the address and register index of the very next request. A corrupted saved mask stays hidden while busy holds the output at zero. It appears on wim_o in the first idle cycle, the same cycle as the done pulse. The bench therefore compares the mask there and again before the following operation.

// File: rtl/rwin_pkg.sv
package rwin_pkg;
  localparam int DW        = 64;
  localparam int REG_W     = 5;
  localparam int PAIRS     = 8;
  localparam int PAIR_W    = $clog2(PAIRS);
  localparam logic [REG_W-1:0] SP_REG    = 5'd14;
  localparam logic [REG_W-1:0] FIRST_REG = 5'd16;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_BASE,
    ST_REQ,
    ST_WAIT,
    ST_COMMIT
  } seq_state_e;
endpackage

// File: rtl/rwin_ctl.sv
module rwin_ctl
  import rwin_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic start_i,
  input  logic misalign_i,
  input  logic req_ready_i,
  input  logic rsp_valid_i,
  input  logic last_i,
  output logic busy_o,
  output logic accept_o,
  output logic sel_sp_o,
  output logic base_load_o,
  output logic abort_o,
  output logic req_valid_o,
  output logic in_wait_o,
  output logic pair_adv_o,
  output logic commit_o,
  output logic done_o,
  output logic err_o
);
  seq_state_e state_q, state_d;
  logic done_q, err_q;

  assign busy_o      = (state_q != ST_IDLE);
  assign accept_o    = (state_q == ST_IDLE) && start_i;
  assign sel_sp_o    = (state_q == ST_BASE);
  assign base_load_o = sel_sp_o && !misalign_i;
  assign abort_o     = sel_sp_o && misalign_i;
  assign req_valid_o = (state_q == ST_REQ);
  assign in_wait_o   = (state_q == ST_WAIT);
  assign pair_adv_o  = in_wait_o && rsp_valid_i && !last_i;
  assign commit_o    = (state_q == ST_COMMIT);
  assign done_o      = done_q;
  assign err_o       = err_q;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:   if (start_i) state_d = ST_BASE;
      ST_BASE:   state_d = misalign_i ? ST_IDLE : ST_REQ;
      ST_REQ:    if (req_ready_i) state_d = ST_WAIT;
      ST_WAIT:   if (rsp_valid_i) state_d = last_i ? ST_COMMIT : ST_REQ;
      ST_COMMIT: state_d = ST_IDLE;
      default:   state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      done_q  <= 1'b0;
      err_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      done_q  <= commit_o;
      if (abort_o)       err_q <= 1'b1;
      else if (accept_o) err_q <= 1'b0;
    end
  end

  // R2: an accepted start makes the engine busy on the next cycle
  a_r2_busy_after_accept: assert property (@(posedge clk) disable iff (!rst_n)
    accept_o |=> busy_o);
  // R7: a request not taken stays asserted
  a_r7_req_held: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid_o && !req_ready_i |=> req_valid_o);
endmodule

// File: rtl/rwin_addr.sv
module rwin_addr
  import rwin_pkg::*;
#(
  parameter int NWIN = 8,
  parameter int AW   = 32,
  parameter int WP_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             accept_i,
  input  logic             kind_i,
  input  logic [WP_W-1:0]  cwp_i,
  input  logic             sel_sp_i,
  input  logic             base_load_i,
  input  logic [31:0]      sp_word_i,
  input  logic             pair_adv_i,
  output logic [WP_W-1:0]  win_o,
  output logic [REG_W-1:0] reg_o,
  output logic [AW-1:0]    addr_o,
  output logic             misalign_o,
  output logic             last_o,
  output logic             kind_o
);
  logic [WP_W:0]     win_sum;
  logic [WP_W-1:0]   win_q;
  logic              kind_q;
  logic [PAIR_W-1:0] pair_q;
  logic [AW-1:0]     base_q;

  always_comb begin
    win_sum = {1'b0, cwp_i} + (kind_i ? (WP_W+1)'(2) : (WP_W+1)'(NWIN-1));
    if (win_sum >= (WP_W+1)'(NWIN)) win_sum = win_sum - (WP_W+1)'(NWIN);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      win_q  <= '0;
      kind_q <= 1'b0;
      pair_q <= '0;
      base_q <= '0;
    end else begin
      if (accept_i) begin
        win_q  <= win_sum[WP_W-1:0];
        kind_q <= kind_i;
        pair_q <= '0;
      end else if (pair_adv_i) begin
        pair_q <= pair_q + 1'b1;
      end
      if (base_load_i) base_q <= AW'(sp_word_i);
    end
  end

  assign misalign_o = |sp_word_i[2:0];
  assign win_o      = win_q;
  assign kind_o     = kind_q;
  assign last_o     = (pair_q == PAIR_W'(PAIRS-1));
  assign reg_o      = sel_sp_i ? SP_REG : FIRST_REG + REG_W'({pair_q, 1'b0});
  assign addr_o     = base_q + AW'({pair_q, 3'b000});
endmodule

// File: rtl/rwin_mask.sv
module rwin_mask #(
  parameter int              NWIN     = 8,
  parameter logic [NWIN-1:0] INIT_WIM = NWIN'(1)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            accept_i,
  input  logic            abort_i,
  input  logic            commit_i,
  input  logic            kind_i,
  output logic [NWIN-1:0] wim_o
);
  logic [NWIN-1:0] wim_q, saved_q, rot_right, rot_left;

  for (genvar i = 0; i < NWIN; i++) begin : g_rot
    assign rot_right[i] = saved_q[(i + 1) % NWIN];
    assign rot_left[i]  = saved_q[(i + NWIN - 1) % NWIN];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wim_q   <= INIT_WIM;
      saved_q <= INIT_WIM;
    end else if (accept_i) begin
      saved_q <= wim_q;
      wim_q   <= '0;
    end else if (abort_i) begin
      wim_q   <= saved_q;
    end else if (commit_i) begin
      wim_q   <= kind_i ? rot_left : rot_right;
    end
  end

  assign wim_o = wim_q;

  // R9/R10: a rotation neither gains nor loses set bits
  a_r9_rotation_keeps_ones: assert property (@(posedge clk) disable iff (!rst_n)
    commit_i |=> $countones(wim_o) == $countones($past(saved_q)));
endmodule

// File: rtl/rwin_spill_fill.sv
module rwin_spill_fill
  import rwin_pkg::*;
#(
  parameter int              NWIN     = 8,
  parameter int              AW       = 32,
  parameter logic [NWIN-1:0] INIT_WIM = NWIN'(1),
  localparam int             WP_W     = (NWIN > 1) ? $clog2(NWIN) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic             kind_i,
  input  logic [WP_W-1:0]  cwp_i,
  output logic             busy_o,
  output logic             done_o,
  output logic             err_o,
  output logic [NWIN-1:0]  wim_o,
  output logic [WP_W-1:0]  rf_win_o,
  output logic [REG_W-1:0] rf_reg_o,
  input  logic [DW-1:0]    rf_rdata_i,
  output logic             rf_we_o,
  output logic [DW-1:0]    rf_wdata_o,
  output logic             mem_req_valid_o,
  input  logic             mem_req_ready_i,
  output logic             mem_req_write_o,
  output logic [AW-1:0]    mem_req_addr_o,
  output logic [DW-1:0]    mem_req_wdata_o,
  input  logic             mem_rsp_valid_i,
  input  logic [DW-1:0]    mem_rsp_rdata_i
);
  logic accept, sel_sp, base_load, abort, in_wait, pair_adv, commit;
  logic misalign, last, kind_q;

  rwin_ctl u_ctl (
    .clk         (clk),
    .rst_n       (rst_n),
    .start_i     (start_i),
    .misalign_i  (misalign),
    .req_ready_i (mem_req_ready_i),
    .rsp_valid_i (mem_rsp_valid_i),
    .last_i      (last),
    .busy_o      (busy_o),
    .accept_o    (accept),
    .sel_sp_o    (sel_sp),
    .base_load_o (base_load),
    .abort_o     (abort),
    .req_valid_o (mem_req_valid_o),
    .in_wait_o   (in_wait),
    .pair_adv_o  (pair_adv),
    .commit_o    (commit),
    .done_o      (done_o),
    .err_o       (err_o)
  );

  rwin_addr #(.NWIN(NWIN), .AW(AW), .WP_W(WP_W)) u_addr (
    .clk         (clk),
    .rst_n       (rst_n),
    .accept_i    (accept),
    .kind_i      (kind_i),
    .cwp_i       (cwp_i),
    .sel_sp_i    (sel_sp),
    .base_load_i (base_load),
    .sp_word_i   (rf_rdata_i[DW-1:32]),
    .pair_adv_i  (pair_adv),
    .win_o       (rf_win_o),
    .reg_o       (rf_reg_o),
    .addr_o      (mem_req_addr_o),
    .misalign_o  (misalign),
    .last_o      (last),
    .kind_o      (kind_q)
  );

  rwin_mask #(.NWIN(NWIN), .INIT_WIM(INIT_WIM)) u_mask (
    .clk      (clk),
    .rst_n    (rst_n),
    .accept_i (accept),
    .abort_i  (abort),
    .commit_i (commit),
    .kind_i   (kind_q),
    .wim_o    (wim_o)
  );

  assign mem_req_write_o = !kind_q;
  assign mem_req_wdata_o = rf_rdata_i;
  assign rf_we_o         = in_wait && mem_rsp_valid_i && kind_q;
  assign rf_wdata_o      = mem_rsp_rdata_i;

  // R8: traps masked for the whole operation
  a_r8_mask_zero_busy: assert property (@(posedge clk) disable iff (!rst_n)
    busy_o |-> wim_o == '0);
  // R7: a stalled request keeps its address and direction
  a_r7_req_stable: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid_o && !mem_req_ready_i |=>
      mem_req_valid_o && $stable(mem_req_addr_o) && $stable(mem_req_write_o));
  // R4: every request is doubleword aligned
  a_r4_req_aligned: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid_o |-> mem_req_addr_o[2:0] == 3'b000);
  // R11: done follows the busy period
  a_r11_done_after_busy: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> !busy_o && $past(busy_o));
  // R12: an error never coexists with memory traffic
  a_r12_err_no_req: assert property (@(posedge clk) disable iff (!rst_n)
    err_o |-> !mem_req_valid_o);
endmodule

// File: tb/test_rwin_spill_fill.sv
module test_rwin_spill_fill;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0, kind = 1'b0;
  logic [2:0]  cwp = '0;
  logic        busy, done, err;
  logic [7:0]  wim;
  logic [2:0]  rf_win;
  logic [4:0]  rf_reg;
  logic [63:0] rf_rdata, rf_wdata;
  logic        rf_we;
  logic        req_valid, req_ready = 1'b0, req_write;
  logic [31:0] req_addr;
  logic [63:0] req_wdata;
  logic        rsp_valid = 1'b0;
  logic [63:0] rsp_rdata = '0;

  logic [31:0] rf  [8][32];
  logic [63:0] mem [512];
  logic [7:0]  wim_model = 8'h01;
  int vectors = 0, fails = 0;

  always #2 clk = ~clk;

  assign rf_rdata = {rf[rf_win][rf_reg], rf[rf_win][rf_reg | 5'd1]};

  rwin_spill_fill i_rwin_spill_fill (
    .clk(clk), .rst_n(rst_n), .start_i(start), .kind_i(kind), .cwp_i(cwp),
    .busy_o(busy), .done_o(done), .err_o(err), .wim_o(wim),
    .rf_win_o(rf_win), .rf_reg_o(rf_reg), .rf_rdata_i(rf_rdata),
    .rf_we_o(rf_we), .rf_wdata_o(rf_wdata),
    .mem_req_valid_o(req_valid), .mem_req_ready_i(req_ready),
    .mem_req_write_o(req_write), .mem_req_addr_o(req_addr),
    .mem_req_wdata_o(req_wdata), .mem_rsp_valid_i(rsp_valid),
    .mem_rsp_rdata_i(rsp_rdata));

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    vectors++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] rot_exp(input logic [7:0] m, input bit fill);
    return fill ? {m[6:0], m[7]} : {m[0], m[7:1]};
  endfunction

  function automatic int tgt_win(input bit fill, input int c);
    return fill ? (c + 2) % 8 : (c + 7) % 8;
  endfunction

  task automatic run_op(input bit fill, input int c, input int stall_max, input int lat_max, input bit poke);
    int w;
    logic [31:0] sp;
    logic [7:0]  exp_wim;
    logic [63:0] exp_pair [8];
    logic [31:0] hs_addr;
    logic [63:0] hs_data, cap_data;
    logic        hs_write, cap_we;
    logic [4:0]  cap_reg;
    w = tgt_win(fill, c);
    sp = rf[w][14];
    exp_wim = rot_exp(wim_model, fill);
    for (int k = 0; k < 8; k++)
      exp_pair[k] = fill ? mem[sp[11:3] + 9'(k)] : {rf[w][16+2*k], rf[w][17+2*k]};
    @(negedge clk); start = 1'b1; kind = fill; cwp = 3'(c);
    @(negedge clk); start = 1'b0;
    chk(busy == 1'b1, "R2 busy after start", 64'(busy), 64'd1);
    chk(wim == 8'h00, "R8 mask zero while busy", 64'(wim), 64'd0);
    chk(rf_win == 3'(w), "R3 target window", 64'(rf_win), 64'(w));
    chk(rf_reg == 5'd14, "R3 stack pointer register", 64'(rf_reg), 64'd14);
    chk(err == 1'b0, "R12 error cleared by start", 64'(err), 64'd0);
    for (int k = 0; k < 8; k++) begin
      int guard = 0;
      int stall = $urandom_range(0, stall_max);
      int lat = poke ? 2 : $urandom_range(0, lat_max);
      while (!req_valid && guard < 40) begin @(negedge clk); guard++; end
      chk(req_valid == 1'b1, "R7 request issued", 64'(req_valid), 64'd1);
      for (int s = 0; s < stall; s++) begin
        @(negedge clk);
        chk(req_valid && req_addr == sp + 32'(8*k), "R7 request held under stall", 64'(req_addr), 64'(sp + 32'(8*k)));
      end
      chk(req_addr == sp + 32'(8*k), "R4 address offset", 64'(req_addr), 64'(sp + 32'(8*k)));
      chk(rf_reg == 5'(16 + 2*k), "R4 pair order", 64'(rf_reg), 64'(16 + 2*k));
      chk(req_write == !fill, "R5 R6 direction", 64'(req_write), 64'(!fill));
      if (!fill) chk(req_wdata == exp_pair[k], "R5 spill data", req_wdata, exp_pair[k]);
      req_ready = 1'b1;
      hs_addr = req_addr; hs_write = req_write; hs_data = req_wdata;
      @(negedge clk); req_ready = 1'b0;
      if (hs_write) mem[hs_addr[11:3]] = hs_data;
      for (int l = 0; l < lat; l++) begin
        chk(req_valid == 1'b0, "R7 one transfer in flight", 64'(req_valid), 64'd0);
        if (poke && k == 0 && l == 0) begin
          start = 1'b1; kind = !fill; cwp = 3'(c + 3);   // R2: must be ignored
        end
        @(negedge clk); start = 1'b0;
      end
      rsp_valid = 1'b1;
      rsp_rdata = fill ? mem[hs_addr[11:3]] : {$urandom, $urandom};
      #1;
      chk(rf_we == fill, "R6 register write enable", 64'(rf_we), 64'(fill));
      if (fill) begin
        chk(rf_reg == 5'(16 + 2*k) && rf_win == 3'(w), "R6 fill register target", 64'(rf_reg), 64'(16 + 2*k));
        chk(rf_wdata == exp_pair[k], "R6 fill data", rf_wdata, exp_pair[k]);
      end
      cap_we = rf_we; cap_reg = rf_reg; cap_data = rf_wdata;
      @(negedge clk); rsp_valid = 1'b0;
      if (cap_we) begin
        rf[w][cap_reg] = cap_data[63:32];
        rf[w][cap_reg | 5'd1] = cap_data[31:0];
      end
    end
    chk(busy == 1'b1 && wim == 8'h00 && done == 1'b0, "R8 busy until mask update", 64'(wim), 64'd0);
    @(negedge clk);
    chk(busy == 1'b0, "R11 busy falls", 64'(busy), 64'd0);
    chk(done == 1'b1, "R11 done pulse", 64'(done), 64'd1);
    if (fill) chk(wim == exp_wim, "R10 rotate left", 64'(wim), 64'(exp_wim));
    else      chk(wim == exp_wim, "R9 rotate right", 64'(wim), 64'(exp_wim));
    wim_model = exp_wim;
    @(negedge clk);
    chk(done == 1'b0, "R11 done one cycle", 64'(done), 64'd0);
    for (int k = 0; k < 8; k++) begin
      if (fill) chk({rf[w][16+2*k], rf[w][17+2*k]} == exp_pair[k], "R6 window contents", {rf[w][16+2*k], rf[w][17+2*k]}, exp_pair[k]);
      else      chk(mem[sp[11:3] + 9'(k)] == exp_pair[k], "R5 save area contents", mem[sp[11:3] + 9'(k)], exp_pair[k]);
    end
  endtask

  task automatic run_misaligned(input bit fill, input int c);
    int w = tgt_win(fill, c);
    rf[w][14] = {20'd0, 9'($urandom_range(0, 500)), 3'b100};
    @(negedge clk); start = 1'b1; kind = fill; cwp = 3'(c);
    @(negedge clk); start = 1'b0;
    chk(busy == 1'b1, "R12 busy during base read", 64'(busy), 64'd1);
    @(negedge clk);
    chk(busy == 1'b0, "R12 busy drops", 64'(busy), 64'd0);
    chk(err == 1'b1, "R12 error raised", 64'(err), 64'd1);
    chk(done == 1'b0, "R12 no done", 64'(done), 64'd0);
    chk(req_valid == 1'b0, "R12 no request", 64'(req_valid), 64'd0);
    chk(wim == wim_model, "R12 mask restored", 64'(wim), 64'(wim_model));
    @(negedge clk);
    chk(err == 1'b1 && req_valid == 1'b0, "R12 error held", 64'(err), 64'd1);
    rf[w][14] = {20'd0, 9'($urandom_range(0, 500)), 3'b000};
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed));
    for (int i = 0; i < 8; i++)
      for (int j = 0; j < 32; j++) rf[i][j] = $urandom;
    for (int i = 0; i < 8; i++) rf[i][14] = {20'd0, 9'($urandom_range(0, 500)), 3'b000};
    for (int i = 0; i < 512; i++) mem[i] = {$urandom, $urandom};
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(busy == 1'b0 && done == 1'b0 && err == 1'b0, "R1 reset flags", {busy, done, err}, 3'b000);
    chk(wim == 8'h01, "R1 reset mask", 64'(wim), 64'h01);
    chk(req_valid == 1'b0 && rf_we == 1'b0, "R1 reset idle ports", {req_valid, rf_we}, 2'b00);
    // directed: wrap of window and mask in both directions
    run_op(1'b0, 0, 0, 0, 1'b0);   // spill from cwp 0 -> window 7, mask 01 -> 80
    run_op(1'b1, 6, 2, 2, 1'b0);   // fill window 0, mask 80 -> 01
    run_op(1'b1, 7, 3, 3, 1'b1);   // fill window 1 with an ignored start mid-way
    run_misaligned(1'b0, 3);
    run_op(1'b0, 3, 1, 1, 1'b0);   // clears the error
    for (int n = 0; n < 24; n++) begin
      bit f = 1'($urandom_range(0, 1));
      int c = $urandom_range(0, 7);
      rf[tgt_win(f, c)][14] = {20'd0, 9'($urandom_range(0, 500)), 3'b000};
      if (n % 8 == 5) run_misaligned(f, c);
      else run_op(f, c, 3, 3, 1'b0);
    end
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule